// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Active-Low Flags

This block buffers bytes between two clock domains that may run asynchronously or share one clock. A writer offers a byte on every rising write-clock edge by pulling its enable low; a reader pulls a byte into a held output register on every rising read-clock edge by pulling its own enable low. Storage depth is a parameter (a power of two from 256 to 4096 entries).

Back-pressure works through two active-low flags, each owned by one clock domain. A low `full_n` tells the writer to stall, and any byte offered while it is low is dropped. A low `empty_n` tells the reader that no byte is available, and a read request made while it is low leaves the output register untouched. The pointers cross domains as Gray codes through two-flop synchronizers. A flag therefore reacts at once to its own domain's traffic and releases after the other side's traffic with a lag of two destination edges. That lag is one to two destination periods in time. The output bus is modelled as a data vector plus a drive-enable signal. A single active-low reset is applied asynchronously and released synchronously in each domain.

Top module: `bytefifo_dc`

## Requirements
- R1: While `rst_n` is low, `full_n` is 1, `empty_n` is 0 and the output register reads 0x00; afterwards the FIFO is empty.
- R2: On a rising `wr_clk` edge with `wr_en_n` = 0 and `full_n` = 1, `wr_data` is stored at the tail of the queue.
- R3: With no reads, `full_n` is still 1 after DEPTH-1 stored writes and goes 0 right after the DEPTH-th write edge. Writes offered while `full_n` = 0 store nothing.
- R4: On a rising `rd_clk` edge with `rd_en_n` = 0 and `empty_n` = 1, the oldest stored byte moves into the output register, so bytes leave in write order.
- R5: While `rd_en_n` = 1, the output register keeps its value.
- R6: While `empty_n` = 0, `rd_en_n` is ignored and the output register keeps its value.
- R7: After a write into an empty FIFO, `empty_n` rises on the second rising `rd_clk` edge after that write edge, and not earlier.
- R8: After a read from a full FIFO, `full_n` rises on the second rising `wr_clk` edge after that read edge, and not earlier.
- R9: With `oe_n` = 1, `rd_drive` is 0 and `rd_q` is 0x00 (bus released). With `oe_n` = 0, `rd_drive` is 1 and `rd_q` shows the output register.
- R10: The read edge that takes the last stored byte drives `empty_n` to 0 on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset for both domains |
| wr_clk | input | 1 | Write-domain clock |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DATA_W | Byte to store |
| full_n | output | 1 | Active-low full flag, write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_en_n | input | 1 | Active-low read request |
| oe_n | input | 1 | Active-low output drive enable |
| rd_q | output | DATA_W | Output register value when driven, 0 when released |
| rd_drive | output | 1 | High when the output bus is driven |
| empty_n | output | 1 | Active-low empty flag, read domain |

## Verification
A corrupted write or read pointer appears at `rd_q` on the next accepted read as a byte out of order, a repeated byte or a missing byte. It also leaves the queue with the wrong length, which shows when the reads that drain it do not end with `empty_n` low. A synchronizer with the wrong stage count, or a flag compare against the wrong pointer form, moves a flag release away from the second destination edge, so an edge count taken right after a single write or read shows the fault. A wrong full compare shows up at the DEPTH-th write of an uninterrupted fill.

// File: rtl/bytefifo_pkg.sv
package bytefifo_pkg;
  // widest pointer needed for the largest supported depth (4096 entries + wrap bit)
  localparam int PTR_MAX_W   = 13;
  localparam int SYNC_STAGES = 2;

  typedef logic [PTR_MAX_W-1:0] ptr_t;

  function automatic ptr_t to_gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/bytefifo_rst_sync.sv
module bytefifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/bytefifo_gray_sync.sv
module bytefifo_gray_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/bytefifo_wr_side.sv
module bytefifo_wr_side
  import bytefifo_pkg::*;
#(
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic [PW-1:0] rd_gray_sync,
  output logic          full_n,
  output logic          store,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] gray
);
  logic [PW-1:0] bin, bin_next, gray_next, rd_gray_flip;

  // full when the writer is exactly one lap ahead of the reader
  assign rd_gray_flip = {~rd_gray_sync[PW-1:PW-2], rd_gray_sync[PW-3:0]};
  assign full_n       = (gray != rd_gray_flip);
  assign store        = ~en_n & full_n;
  assign bin_next     = bin + PW'(store);
  assign gray_next    = PW'(to_gray(ptr_t'(bin_next)));
  assign waddr        = bin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin  <= '0;
      gray <= '0;
    end else begin
      bin  <= bin_next;
      gray <= gray_next;
    end
  end
endmodule

// File: rtl/bytefifo_rd_side.sv
module bytefifo_rd_side
  import bytefifo_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DATA_W = 8,
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic [PW-1:0]     wr_gray_sync,
  input  logic [DATA_W-1:0] mem_data,
  output logic              empty_n,
  output logic [AW-1:0]     raddr,
  output logic [PW-1:0]     gray,
  output logic [DATA_W-1:0] out_reg
);
  logic [PW-1:0] bin, bin_next, gray_next;
  logic          take;

  assign empty_n   = (gray != wr_gray_sync);
  assign take      = ~en_n & empty_n;
  assign bin_next  = bin + PW'(take);
  assign gray_next = PW'(to_gray(ptr_t'(bin_next)));
  assign raddr     = bin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin     <= '0;
      gray    <= '0;
      out_reg <= '0;
    end else begin
      bin  <= bin_next;
      gray <= gray_next;
      if (take) out_reg <= mem_data;
    end
  end
endmodule

// File: rtl/bytefifo_dc.sv
module bytefifo_dc
  import bytefifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_n,
  input  logic              rd_clk,
  input  logic              rd_en_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_drive,
  output logic              empty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic              wr_rst_n, rd_rst_n;
  logic              wr_store;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [PW-1:0]     wr_gray, rd_gray, wr_gray_in_rd, rd_gray_in_wr;
  logic [DATA_W-1:0] rd_reg;
  logic [DATA_W-1:0] mem [DEPTH];

  bytefifo_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .rst_n(rst_n), .rst_n_sync(wr_rst_n));
  bytefifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .rst_n(rst_n), .rst_n_sync(rd_rst_n));

  bytefifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_in_wr));
  bytefifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_in_rd));

  bytefifo_wr_side #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .en_n(wr_en_n),
    .rd_gray_sync(rd_gray_in_wr), .full_n(full_n),
    .store(wr_store), .waddr(wr_addr), .gray(wr_gray));

  bytefifo_rd_side #(.AW(AW), .DATA_W(DATA_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .en_n(rd_en_n),
    .wr_gray_sync(wr_gray_in_rd), .mem_data(mem[rd_addr]),
    .empty_n(empty_n), .raddr(rd_addr), .gray(rd_gray), .out_reg(rd_reg));

  always_ff @(posedge wr_clk) begin
    if (wr_store) mem[wr_addr] <= wr_data;
  end

  assign rd_drive = ~oe_n;
  assign rd_q     = rd_drive ? rd_reg : '0;
endmodule

// File: rtl/bytefifo_dc_chk.sv
module bytefifo_dc_chk #(
  parameter int PW     = 9,
  parameter int DATA_W = 8
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              wr_rst_n,
  input logic              rd_rst_n,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic              full_n,
  input logic              empty_n,
  input logic [PW-1:0]     wr_gray,
  input logic [PW-1:0]     rd_gray,
  input logic [DATA_W-1:0] rd_reg
);
  always @(negedge rd_clk) begin
    if (!rd_rst_n) AST_RESET_RD: assert (!empty_n && rd_reg == '0) else $error("read side not cleared"); // R1
  end

  always @(negedge wr_clk) begin
    if (!wr_rst_n) AST_RESET_WR: assert (full_n) else $error("full flag low in reset"); // R1
  end

  AST_WRITE_ADV: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (!wr_en_n && full_n) |=> !$stable(wr_gray)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !full_n |=> $stable(wr_gray)); // R3

  AST_HOLD_IDLE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_en_n |=> $stable(rd_reg)); // R5

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !empty_n |=> ($stable(rd_gray) && $stable(rd_reg))); // R6
endmodule

bind bytefifo_dc bytefifo_dc_chk #(.PW(PW), .DATA_W(DATA_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .full_n(full_n), .empty_n(empty_n),
  .wr_gray(wr_gray), .rd_gray(rd_gray), .rd_reg(rd_reg));

// File: tb/test_bytefifo_dc.sv
module test_bytefifo_dc;
  localparam int CLK_PERIOD = 20;
  localparam int RD_PERIOD  = CLK_PERIOD * 3 / 2;
  localparam int DEPTH      = 256;

  logic       rst_n = 1'b0;
  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_en_n = 1'b1, rd_en_n = 1'b1, oe_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_q;
  logic       full_n, empty_n, rd_drive;

  int         n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_q = '0;
  bit         rd_pend = 1'b0;

  bytefifo_dc #(.DEPTH(DEPTH), .DATA_W(8)) i_bytefifo_dc (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .full_n(full_n), .rd_clk(rd_clk), .rd_en_n(rd_en_n), .oe_n(oe_n),
    .rd_q(rd_q), .rd_drive(rd_drive), .empty_n(empty_n));

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  initial begin
    #(RD_PERIOD/2);
    forever #(RD_PERIOD/2) rd_clk = ~rd_clk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // write monitor: a byte offered while full_n is high is expected downstream
  always @(negedge wr_clk) begin
    if (rst_n && !wr_en_n && full_n) exp_q.push_back(wr_data);
  end

  // read monitor: compares the output register after every accepted read
  always @(negedge rd_clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 read with no expected byte", rd_q, 0);
      else begin
        last_q = exp_q.pop_front();
        chk(rd_q == last_q, "R4 byte order", rd_q, last_q);
      end
    end
    rd_pend = rst_n && !rd_en_n && empty_n;
  end

  task automatic push_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(posedge wr_clk); #1;
      wr_en_n = 1'b0;
      wr_data = 8'(base + i * 7);
    end
    @(posedge wr_clk); #1;
    wr_en_n = 1'b1;
  endtask

  task automatic pull(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge rd_clk); #1;
      rd_en_n = 1'b0;
    end
    @(posedge rd_clk); #1;
    rd_en_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int n;
    logic [7:0] held;
    // R1: state during reset
    repeat (3) @(negedge wr_clk);
    chk(full_n == 1'b1, "R1 full_n in reset", full_n, 1);
    chk(empty_n == 1'b0, "R1 empty_n in reset", empty_n, 0);
    chk(rd_q == 8'h00, "R1 output register in reset", rd_q, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge wr_clk);

    // R7: empty release after a single write
    push_bytes(1, 8'h5A);
    chk(empty_n == 1'b0, "R7 empty_n right after write", empty_n, 0);
    n = 0;
    while (!empty_n && n < 10) begin @(posedge rd_clk); #1; n++; end
    chk(n == 2, "R7 read edges to empty release", n, 2);

    // R10: taking the last byte empties on that edge
    pull(1);
    chk(empty_n == 1'b0, "R10 empty_n after last read", empty_n, 0);
    @(negedge rd_clk); #1;

    // R6: reads while empty are ignored
    held = rd_q;
    pull(3);
    @(negedge rd_clk); #1;
    chk(rd_q == held, "R6 output held while empty", rd_q, held);

    // R2/R5: store a burst, then hold the output with reads idle
    push_bytes(20, 8'h11);
    repeat (6) @(negedge rd_clk);
    chk(rd_q == held, "R5 output held while rd_en_n high", rd_q, held);
    pull(20);
    repeat (4) @(negedge rd_clk);
    chk(exp_q.size() == 0, "R2 all stored bytes read", exp_q.size(), 0);
    chk(empty_n == 1'b0, "R2 empty after drain", empty_n, 0);

    // R4: concurrent write and read traffic
    fork
      push_bytes(60, 8'h30);
      pull(70);
    join
    repeat (6) @(negedge rd_clk);
    pull(exp_q.size() + 2);
    repeat (4) @(negedge rd_clk);
    chk(exp_q.size() == 0, "R4 concurrent traffic drained", exp_q.size(), 0);

    // R3: full after exactly DEPTH writes; writes while full dropped
    push_bytes(DEPTH - 1, 8'h03);
    chk(full_n == 1'b1, "R3 full_n after DEPTH-1 writes", full_n, 1);
    push_bytes(1, 8'hC4);
    chk(full_n == 1'b0, "R3 full_n after DEPTH writes", full_n, 0);
    push_bytes(4, 8'hE1);
    chk(full_n == 1'b0, "R3 full_n after writes while full", full_n, 0);
    chk(exp_q.size() == DEPTH, "R3 accepted byte count", exp_q.size(), DEPTH);

    // R8: full release after a single read
    repeat (4) @(posedge rd_clk);
    pull(1);
    chk(full_n == 1'b0, "R8 full_n right after read", full_n, 0);
    n = 0;
    while (!full_n && n < 10) begin @(posedge wr_clk); #1; n++; end
    chk(n == 2, "R8 write edges to full release", n, 2);

    pull(DEPTH + 4);
    repeat (4) @(negedge rd_clk);
    chk(exp_q.size() == 0, "R3 no dropped byte reappears", exp_q.size(), 0);
    chk(empty_n == 1'b0, "R10 empty after full drain", empty_n, 0);

    // R9: drive enable
    oe_n = 1'b1; #1;
    chk(rd_drive == 1'b0, "R9 drive off", rd_drive, 0);
    chk(rd_q == 8'h00, "R9 bus released value", rd_q, 0);
    oe_n = 1'b0; #1;
    chk(rd_drive == 1'b1, "R9 drive on", rd_drive, 1);
    chk(rd_q == last_q, "R9 bus shows register", rd_q, last_q);

    // R1: reset in mid-run
    push_bytes(5, 8'h71);
    repeat (5) @(negedge rd_clk);
    pull(1);
    repeat (2) @(negedge rd_clk);
    rst_n = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge wr_clk);
    chk(full_n == 1'b1, "R1 full_n mid-run reset", full_n, 1);
    chk(empty_n == 1'b0, "R1 empty_n mid-run reset", empty_n, 0);
    chk(rd_q == 8'h00, "R1 output cleared mid-run reset", rd_q, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge wr_clk);
    chk(empty_n == 1'b0, "R1 empty after reset release", empty_n, 0);
    report();
  end
endmodule